// File: doc/BRIEF.md
# Line and Fault Protection Sequencer

This block decides when an off-line switching power stage is allowed to switch. It receives single-bit flags from analog comparators that watch the input line, the controller supply, the compensation node and the die temperature. It also receives a soft-start completion flag, a one-millisecond tick and a strap that says whether line sensing is wired up. From these it drives three registered outputs: a switching enable, a soft-start request and a protection-mode flag that starts the auto-restart wait in the supply logic.

Each fault path has its own persistence window, counted in ticks. A window restarts from zero whenever its condition drops before it expires. Line over-voltage only pauses switching until the line falls back below its recover level, and then the block resumes through a fresh soft-start. Brown-out, supply over-voltage, overload and over-temperature all force a protection cycle. That cycle lasts a fixed auto-restart time and then returns to the startup state. After an over-temperature trip the cycle cannot end until the temperature-recovered flag is set. The overload window is only armed once soft-start has finished. When the line-sense strap is low, the three line checks have no effect.

Top module: `prot_sequencer`

## Requirements
- R1: During reset and after it, all three outputs are 0. With line sensing enabled, switching stays off (sw_en=0) for as long as line_lo_bi=1 in the startup state.
- R2: Leaving the startup state enters soft-start on the next clock, with sw_en=1, ss_req=1 and prot_mode=0. When ss_done=1 in soft-start, the next clock gives run, with sw_en=1 and ss_req=0.
- R3: With line sensing enabled, line_lo_bo held high during soft-start or run for BO_MS (100) ticks enters protection (prot_mode=1, sw_en=0). After BO_MS-1 ticks the block is still switching.
- R4: line_hi_ovp held high for LOVP_MS (2) ticks during soft-start or run gives sw_en=0 with prot_mode=0. The halt lasts until line_lo_rec=1. The block then enters soft-start (ss_req=1) and does not enter protection.
- R5: comp_hi_olp held high for OLP_MS (60) ticks in run enters protection. In soft-start, comp_hi_olp has no effect however long it lasts, and its window starts counting only from entry into run.
- R6: vcc_ovp held high for VOVP_MS (6) ticks in soft-start, run or line halt enters protection. After 5 ticks the block has not tripped.
- R7: temp_hot=1 in soft-start, run or line halt enters protection on the next clock. After an over-temperature trip, protection does not end, even after the auto-restart time, until temp_ok=1.
- R8: Protection lasts AR_MS (800) ticks and then returns to the startup state. With the line good, soft-start follows one clock later.
- R9: With line_det_en=0, line_lo_bi, line_lo_bo, line_hi_ovp and line_lo_rec have no effect: startup proceeds at once and run continues.
- R10: Each persistence window restarts from zero when its condition drops before expiry, so separate pulses shorter than the window never trip.
- R11: When a protection fault and a line over-voltage expiry occur in the same cycle, protection is entered (prot_mode=1), not the line halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_det_en | input | 1 | Strap: 1 when line sensing is connected |
| line_lo_bi | input | 1 | Line below brown-in level |
| line_lo_bo | input | 1 | Line below brown-out level |
| line_hi_ovp | input | 1 | Line above over-voltage trip level |
| line_lo_rec | input | 1 | Line below over-voltage recover level |
| vcc_ovp | input | 1 | Controller supply above over-voltage level |
| comp_hi_olp | input | 1 | Compensation node above overload level |
| temp_hot | input | 1 | Die temperature above shutdown level |
| temp_ok | input | 1 | Die temperature below resume level |
| ss_done | input | 1 | Soft-start ramp has completed |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| sw_en | output | 1 | Switching allowed |
| ss_req | output | 1 | Soft-start ramp requested |
| prot_mode | output | 1 | Protection mode, auto-restart wait running |

## Verification
Each timed fault is held for one tick less than its window and then for the full window. This separates a window that is too short, too long or counted from the wrong point. Random bursts shorter than their windows, on brown-out, supply over-voltage and overload, show whether the counters really clear between pulses rather than accumulating. Directed sequences cover the cases that tell the paths apart: overload held through soft-start and then counted from run, line over-voltage that halts and resumes without entering protection, a same-cycle clash between over-temperature and line over-voltage, over-temperature blocking restart past the auto-restart time, and the line-sense strap held low while every line flag is asserted.

// File: rtl/prot_seq_pkg.sv
package prot_seq_pkg;

  typedef enum logic [2:0] {
    ST_WAIT_LINE = 3'd0,
    ST_SOFT      = 3'd1,
    ST_RUN       = 3'd2,
    ST_LINE_HALT = 3'd3,
    ST_PROT      = 3'd4
  } seq_state_e;

  // timer slots
  localparam int FI_BO   = 0;
  localparam int FI_LOVP = 1;
  localparam int FI_VOVP = 2;
  localparam int FI_OLP  = 3;
  localparam int FI_AR   = 4;
  localparam int NUM_TMR = 5;

endpackage

// File: rtl/prot_delay_timer.sv
module prot_delay_timer #(
  parameter int unsigned LIMIT = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic cond,
  input  logic tick,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM_C = LIMIT[CW-1:0];

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (!cond) begin
      cnt <= '0;
    end else if (tick && (cnt != LIM_C)) begin
      cnt <= cnt + CW'(1);
    end
  end

  assign expired = cond && (cnt == LIM_C);

  AST_TMR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !cond |=> !expired); // R10

  AST_TMR_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    (cond && !expired && !tick) |=> !expired); // R10

endmodule

// File: rtl/prot_fault_qualify.sv
module prot_fault_qualify
  import prot_seq_pkg::*;
(
  input  seq_state_e           state,
  input  logic                 line_det_en,
  input  logic                 line_lo_bo,
  input  logic                 line_hi_ovp,
  input  logic                 vcc_ovp,
  input  logic                 comp_hi_olp,
  output logic [NUM_TMR-1:0]   tmr_cond
);
  logic switching;
  logic powered;

  always_comb begin
    switching = (state == ST_SOFT) || (state == ST_RUN);
    powered   = switching || (state == ST_LINE_HALT);
    tmr_cond  = '0;
    tmr_cond[FI_BO]   = line_det_en && line_lo_bo  && switching;
    tmr_cond[FI_LOVP] = line_det_en && line_hi_ovp && switching;
    tmr_cond[FI_VOVP] = vcc_ovp && powered;
    tmr_cond[FI_OLP]  = comp_hi_olp && (state == ST_RUN);
    tmr_cond[FI_AR]   = (state == ST_PROT);
  end

endmodule

// File: rtl/prot_seq_fsm.sv
module prot_seq_fsm
  import prot_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               line_det_en,
  input  logic               line_lo_bi,
  input  logic               line_lo_rec,
  input  logic               temp_hot,
  input  logic               temp_ok,
  input  logic               ss_done,
  input  logic [NUM_TMR-1:0] tmr_exp,
  output seq_state_e         state,
  output logic               sw_en,
  output logic               ss_req,
  output logic               prot_mode
);
  seq_state_e nxt;
  logic otp_latch;
  logic prot_fault;
  logic halt_fault;
  logic line_ok;
  logic halt_clear;
  logic restart_ok;

  always_comb begin
    prot_fault = temp_hot || tmr_exp[FI_BO] || tmr_exp[FI_VOVP] || tmr_exp[FI_OLP];
    halt_fault = temp_hot || tmr_exp[FI_VOVP];
    line_ok    = !line_det_en || !line_lo_bi;
    halt_clear = !line_det_en || line_lo_rec;
    restart_ok = tmr_exp[FI_AR] && (!otp_latch || temp_ok);
    nxt = state;
    unique case (state)
      ST_WAIT_LINE: if (line_ok) nxt = ST_SOFT;
      ST_SOFT: begin
        if (prot_fault)             nxt = ST_PROT;
        else if (tmr_exp[FI_LOVP])  nxt = ST_LINE_HALT;
        else if (ss_done)           nxt = ST_RUN;
      end
      ST_RUN: begin
        if (prot_fault)             nxt = ST_PROT;
        else if (tmr_exp[FI_LOVP])  nxt = ST_LINE_HALT;
      end
      ST_LINE_HALT: begin
        if (halt_fault)             nxt = ST_PROT;
        else if (halt_clear)        nxt = ST_SOFT;
      end
      ST_PROT: if (restart_ok) nxt = ST_WAIT_LINE;
      default: nxt = ST_WAIT_LINE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_WAIT_LINE;
      sw_en     <= 1'b0;
      ss_req    <= 1'b0;
      prot_mode <= 1'b0;
      otp_latch <= 1'b0;
    end else begin
      state     <= nxt;
      sw_en     <= (nxt == ST_SOFT) || (nxt == ST_RUN);
      ss_req    <= (nxt == ST_SOFT);
      prot_mode <= (nxt == ST_PROT);
      if (temp_hot)     otp_latch <= 1'b1;
      else if (temp_ok) otp_latch <= 1'b0;
    end
  end

  AST_WAIT_BROWN_IN: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT_LINE && line_det_en && line_lo_bi) |=> !sw_en); // R1

  AST_SS_TO_RUN: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SOFT && ss_done && !prot_fault && !tmr_exp[FI_LOVP]) |=> (sw_en && !ss_req)); // R2

  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LINE_HALT && line_det_en && !line_lo_rec && !halt_fault) |=> (!sw_en && !prot_mode)); // R4

  AST_HALT_RESUME: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LINE_HALT && line_lo_rec && !halt_fault) |=> (ss_req && !prot_mode)); // R4

  AST_OTP_TRIP: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_SOFT || state == ST_RUN) && temp_hot) |=> prot_mode); // R7

  AST_OTP_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (prot_mode && otp_latch && !temp_ok) |=> prot_mode); // R7

  AST_PRIORITY: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_SOFT || state == ST_RUN) && tmr_exp[FI_LOVP] && prot_fault) |=> (prot_mode && !sw_en)); // R11

endmodule

// File: rtl/prot_sequencer.sv
module prot_sequencer
  import prot_seq_pkg::*;
#(
  parameter int unsigned BO_MS   = 100,
  parameter int unsigned LOVP_MS = 2,
  parameter int unsigned VOVP_MS = 6,
  parameter int unsigned OLP_MS  = 60,
  parameter int unsigned AR_MS   = 800
) (
  input  logic clk,
  input  logic rst,
  input  logic line_det_en,
  input  logic line_lo_bi,
  input  logic line_lo_bo,
  input  logic line_hi_ovp,
  input  logic line_lo_rec,
  input  logic vcc_ovp,
  input  logic comp_hi_olp,
  input  logic temp_hot,
  input  logic temp_ok,
  input  logic ss_done,
  input  logic ms_tick,
  output logic sw_en,
  output logic ss_req,
  output logic prot_mode
);
  seq_state_e         state;
  logic [NUM_TMR-1:0] tmr_cond;
  logic [NUM_TMR-1:0] tmr_exp;

  prot_fault_qualify u_qual (
    .state       (state),
    .line_det_en (line_det_en),
    .line_lo_bo  (line_lo_bo),
    .line_hi_ovp (line_hi_ovp),
    .vcc_ovp     (vcc_ovp),
    .comp_hi_olp (comp_hi_olp),
    .tmr_cond    (tmr_cond)
  );

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    localparam int unsigned LIM =
      (i == FI_BO)   ? BO_MS   :
      (i == FI_LOVP) ? LOVP_MS :
      (i == FI_VOVP) ? VOVP_MS :
      (i == FI_OLP)  ? OLP_MS  : AR_MS;
    prot_delay_timer #(.LIMIT(LIM)) u_tmr (
      .clk     (clk),
      .rst     (rst),
      .cond    (tmr_cond[i]),
      .tick    (ms_tick),
      .expired (tmr_exp[i])
    );
  end

  prot_seq_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .line_det_en (line_det_en),
    .line_lo_bi  (line_lo_bi),
    .line_lo_rec (line_lo_rec),
    .temp_hot    (temp_hot),
    .temp_ok     (temp_ok),
    .ss_done     (ss_done),
    .tmr_exp     (tmr_exp),
    .state       (state),
    .sw_en       (sw_en),
    .ss_req      (ss_req),
    .prot_mode   (prot_mode)
  );

endmodule

// File: tb/prot_sequencer_bench.sv
`timescale 1ns/1ps
module prot_sequencer_bench;
  localparam int BO = 100, LOVP = 2, VOVP = 6, OLP = 60, AR = 800;
  localparam int TICK_GAP = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_det_en, line_lo_bi, line_lo_bo, line_hi_ovp, line_lo_rec;
  logic vcc_ovp, comp_hi_olp, temp_hot, temp_ok, ss_done, ms_tick;
  logic sw_en, ss_req, prot_mode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  prot_sequencer u_prot_sequencer (
    .clk(clk), .rst(rst), .line_det_en(line_det_en), .line_lo_bi(line_lo_bi),
    .line_lo_bo(line_lo_bo), .line_hi_ovp(line_hi_ovp), .line_lo_rec(line_lo_rec),
    .vcc_ovp(vcc_ovp), .comp_hi_olp(comp_hi_olp), .temp_hot(temp_hot),
    .temp_ok(temp_ok), .ss_done(ss_done), .ms_tick(ms_tick),
    .sw_en(sw_en), .ss_req(ss_req), .prot_mode(prot_mode)
  );

  typedef enum int {M_OFF, M_SOFT, M_RUN, M_PROT} mode_e;

  // {sw_en, ss_req, prot_mode} expected for each externally visible mode
  function automatic logic [2:0] exp_of(mode_e m);
    case (m)
      M_SOFT:  return 3'b110;
      M_RUN:   return 3'b100;
      M_PROT:  return 3'b001;
      default: return 3'b000;
    endcase
  endfunction

  function automatic mode_e after_burst(int len, int lim);
    return (len >= lim) ? M_PROT : M_RUN;
  endfunction

  task automatic chk(input string req, input mode_e m);
    logic [2:0] exp_v;
    logic [2:0] act;
    exp_v = exp_of(m);
    act = {sw_en, ss_req, prot_mode};
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: got sw/ss/prot=%b expected %b", req, act, exp_v);
    end
  endtask

  task automatic benign(input logic det);
    line_det_en = det; line_lo_bi = 1'b0; line_lo_bo = 1'b0; line_hi_ovp = 1'b0;
    line_lo_rec = 1'b1; vcc_ovp = 1'b0; comp_hi_olp = 1'b0; temp_hot = 1'b0;
    temp_ok = 1'b1; ss_done = 1'b0; ms_tick = 1'b0;
  endtask

  task automatic do_reset(input logic det, input logic bi_low);
    @(negedge clk);
    benign(det);
    line_lo_bi = bi_low;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", M_OFF);
    rst = 1'b0;
  endtask

  task automatic pulse_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      ms_tick = 1'b1;
      @(negedge clk);
      ms_tick = 1'b0;
      repeat (TICK_GAP) @(negedge clk);
    end
  endtask

  task automatic to_run();
    do_reset(1'b1, 1'b0);
    ss_done = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 reach run", M_RUN);
  endtask

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd7121);
    benign(1'b1);

    // R1 / R2: wait for brown-in, then soft-start, then run
    do_reset(1'b1, 1'b1);
    pulse_ticks(10);
    chk("R1 held off below brown-in", M_OFF);
    line_lo_bi = 1'b0;
    @(negedge clk);
    chk("R2 soft-start on brown-in", M_SOFT);
    ss_done = 1'b1;
    @(negedge clk);
    chk("R2 run after ss_done", M_RUN);

    // R3 brown-out window, R8 auto-restart
    line_lo_bo = 1'b1;
    pulse_ticks(BO - 1);
    chk("R3 brown-out one tick early", M_RUN);
    pulse_ticks(1);
    chk("R3 brown-out trips", M_PROT);
    line_lo_bo = 1'b0;
    ss_done = 1'b0;
    pulse_ticks(AR - 1);
    chk("R8 still in protection", M_PROT);
    pulse_ticks(1);
    chk("R8 restart into soft-start", M_SOFT);
    ss_done = 1'b1;
    @(negedge clk);
    chk("R8 run after restart", M_RUN);

    // R10 directed: two near-full bursts separated by one clock
    line_lo_bo = 1'b1;
    pulse_ticks(BO - 1);
    line_lo_bo = 1'b0;
    @(negedge clk);
    line_lo_bo = 1'b1;
    pulse_ticks(BO - 1);
    line_lo_bo = 1'b0;
    @(negedge clk);
    chk("R10 window restarts after drop", M_RUN);

    // R10 random short bursts
    for (int it = 0; it < 16; it++) begin
      int kind;
      int len;
      int lim;
      kind = int'($urandom % 3);
      lim = (kind == 0) ? BO : (kind == 1) ? VOVP : OLP;
      len = 1 + int'($urandom % (lim - 1));
      if (kind == 0) line_lo_bo = 1'b1;
      else if (kind == 1) vcc_ovp = 1'b1;
      else comp_hi_olp = 1'b1;
      pulse_ticks(len);
      line_lo_bo = 1'b0; vcc_ovp = 1'b0; comp_hi_olp = 1'b0;
      @(negedge clk);
      chk("R10 random short burst", after_burst(len, lim));
    end

    // R4 line over-voltage halt and recovery
    line_hi_ovp = 1'b1; line_lo_rec = 1'b0;
    pulse_ticks(LOVP - 1);
    chk("R4 lovp one tick early", M_RUN);
    pulse_ticks(1);
    chk("R4 lovp halts without protection", M_OFF);
    pulse_ticks(20);
    chk("R4 halt held while line high", M_OFF);
    line_hi_ovp = 1'b0;
    ss_done = 1'b0;
    pulse_ticks(3);
    chk("R4 halt held above recover level", M_OFF);
    line_lo_rec = 1'b1;
    @(negedge clk);
    chk("R4 resume via soft-start", M_SOFT);
    ss_done = 1'b1;
    @(negedge clk);
    chk("R4 run after resume", M_RUN);

    // R11 same-cycle clash, then R7 restart blocking
    line_hi_ovp = 1'b1; line_lo_rec = 1'b0;
    pulse_ticks(LOVP - 1);
    ms_tick = 1'b1;
    @(negedge clk);
    ms_tick = 1'b0;
    temp_hot = 1'b1;
    @(negedge clk);
    chk("R11 protection wins over lovp halt", M_PROT);
    temp_hot = 1'b0; temp_ok = 1'b0;
    line_hi_ovp = 1'b0; line_lo_rec = 1'b1; ss_done = 1'b0;
    pulse_ticks(AR + 5);
    chk("R7 restart blocked until temp_ok", M_PROT);
    temp_ok = 1'b1;
    @(negedge clk);
    chk("R7 released to startup", M_OFF);
    @(negedge clk);
    chk("R7 soft-start after release", M_SOFT);

    // R7 immediate trip from run
    to_run();
    temp_hot = 1'b1;
    @(negedge clk);
    chk("R7 over-temperature trips at once", M_PROT);
    temp_hot = 1'b0;

    // R5 overload blanked in soft-start, counted in run
    do_reset(1'b1, 1'b0);
    comp_hi_olp = 1'b1;
    @(negedge clk);
    pulse_ticks(OLP + 10);
    chk("R5 overload ignored in soft-start", M_SOFT);
    ss_done = 1'b1;
    @(negedge clk);
    chk("R5 run with overload present", M_RUN);
    pulse_ticks(OLP - 1);
    chk("R5 overload one tick early", M_RUN);
    pulse_ticks(1);
    chk("R5 overload trips", M_PROT);

    // R6 supply over-voltage
    to_run();
    vcc_ovp = 1'b1;
    pulse_ticks(VOVP - 1);
    chk("R6 supply ovp one tick early", M_RUN);
    pulse_ticks(1);
    chk("R6 supply ovp trips", M_PROT);

    // R9 line sensing disabled
    do_reset(1'b0, 1'b1);
    @(negedge clk);
    chk("R9 startup ignores brown-in flag", M_SOFT);
    ss_done = 1'b1;
    @(negedge clk);
    line_lo_bo = 1'b1; line_hi_ovp = 1'b1; line_lo_rec = 1'b0;
    pulse_ticks(BO + 20);
    chk("R9 line faults ignored", M_RUN);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule